// File: doc/BRIEF.md
# Key-and-Code Lock Controller

A clocked controller for an electronic lock. A user inserts a key, which raises `key_in`. At the moment of insertion the controller compares the 5-bit `code_in` word with a combination fixed when the design is compiled. A match opens the lock. The `open_n` output is active low, and it stays low for as long as the key remains inserted.

Each insertion with the wrong code adds one to a failure count. When the count reaches the limit, the unit enters a latched lockout and raises `alarm`. In lockout the correct combination has no effect. A correct insertion before the limit clears the count.

The active-low `arm_n` input returns the unit to service. It acts at once, and the internal release is synchronised to the clock. A combination of all zeros or all ones is refused when the design is elaborated.

Top module: `keycode_lock`

## Requirements
- R1: While `arm_n` is 0, `open_n` is 1 and `alarm` is 0, without waiting for a clock edge, and the failure count is cleared. The lock evaluates attempts from the third rising clock edge after `arm_n` returns to 1.
- R2: An attempt is a rising clock edge at which `key_in` is 1 after it was 0 at the previous active edge. `code_in` is sampled only at that edge. A key held at 1 across a re-enable is not an attempt until it has been withdrawn.
- R3: An attempt whose `code_in` equals `LOCK_CODE` (bit 4 is the MSB, default 5'b01101) drives `open_n` low from the next cycle. `open_n` stays low while `key_in` stays 1.
- R4: After an edge at which `key_in` is sampled 0 in the open state, `open_n` is 1.
- R5: An attempt with any other code leaves `open_n` at 1 and adds one to the failure count.
- R6: The third failed attempt (`MAX_FAIL`, default 3) since the last re-enable or successful open sets `alarm` to 1 from the next cycle.
- R7: While `alarm` is 1, `open_n` stays 1 even for a correct attempt, and `alarm` stays 1 until `arm_n` is driven to 0.
- R8: A successful open clears the failure count, so failures before it do not count toward the limit.
- R9: Changing `code_in` while the key stays inserted has no effect, even when it changes to the correct combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arm_n | input | 1 | Active-low asynchronous re-enable and reset |
| key_in | input | 1 | 1 when the key is fully inserted |
| code_in | input | CODE_W (5) | Code word presented with the key |
| open_n | output | 1 | 0 while the lock is open |
| alarm | output | 1 | 1 while the unit is locked out |

## Verification
The bench goes after these corner cases:
- **Limit after a success.** It opens the lock between two runs of failures. A design that did not clear the count on success would raise the alarm too early.
- **Correct code in lockout.** It presents the correct combination while locked out. A lockout that leaks would open the lock.
- **Code changed with the key held.** It changes the code to the correct one while the key stays in, which exposes a level-sensitive compare.
- **Key held across re-enable.** It holds the key through a re-enable, which exposes an edge detector that resets to the wrong level.
- **Release timing.** It counts the synchronised release cycles exactly. An off-by-one in the synchroniser would shift every later response by a cycle.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_OPEN    = 2'd1,
    LK_LOCKOUT = 2'd2
  } lk_state_e;
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lock_key_edge.sv
module lock_key_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic key,
  output logic rise
);
  logic key_q;

  // Resets to 1 so a key already held at re-enable is not an attempt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= 1'b1;
    else        key_q <= key;
  end

  assign rise = key & ~key_q;
endmodule

// File: rtl/lock_fail_ctr.sv
module lock_fail_ctr #(
  parameter int MAX_FAIL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic last
);
  localparam int CW = $clog2(MAX_FAIL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr | inc;
    if (clr)                                  cnt_d = '0;
    else if (inc && cnt_q != CW'(MAX_FAIL))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(MAX_FAIL - 1));
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      key,
  input  logic      match,
  input  logic      last_fail,
  output logic      fail_inc,
  output logic      fail_clr,
  output lk_state_e state
);
  lk_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    fail_inc = 1'b0;
    fail_clr = 1'b0;
    unique case (st_q)
      LK_IDLE: begin
        if (rise) begin
          if (match) begin
            st_d     = LK_OPEN;
            fail_clr = 1'b1;
          end else begin
            fail_inc = 1'b1;
            if (last_fail) st_d = LK_LOCKOUT;
          end
        end
      end
      LK_OPEN:    if (!key) st_d = LK_IDLE;
      LK_LOCKOUT: st_d = LK_LOCKOUT;
      default:    st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/keycode_lock.sv
module keycode_lock
  import lock_pkg::*;
#(
  parameter int                 CODE_W    = 5,
  parameter logic [CODE_W-1:0]  LOCK_CODE = 5'b01101,
  parameter int                 MAX_FAIL  = 3,
  parameter int                 SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              arm_n,
  input  logic              key_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              open_n,
  output logic              alarm
);
  localparam logic [CODE_W-1:0] ALL_ONE = {CODE_W{1'b1}};

  generate
    if (LOCK_CODE == '0 || LOCK_CODE == ALL_ONE) begin : g_bad_code
      $error("LOCK_CODE must mix zeros and ones");
    end
  endgenerate

  logic      rst_n;
  logic      rise;
  logic      match;
  logic      last_fail;
  logic      fail_inc;
  logic      fail_clr;
  lk_state_e state;

  lock_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .arst_n(arm_n), .rst_sync_n(rst_n)
  );

  lock_key_edge u_edge (
    .clk(clk), .rst_n(rst_n), .key(key_in), .rise(rise)
  );

  assign match = (code_in == LOCK_CODE);

  lock_fail_ctr #(.MAX_FAIL(MAX_FAIL)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(fail_inc), .clr(fail_clr), .last(last_fail)
  );

  lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .key(key_in), .match(match),
    .last_fail(last_fail), .fail_inc(fail_inc), .fail_clr(fail_clr),
    .state(state)
  );

  assign open_n = (state != LK_OPEN);
  assign alarm  = (state == LK_LOCKOUT);
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
  parameter int                CODE_W    = 5,
  parameter logic [CODE_W-1:0] LOCK_CODE = 5'b01101
) (
  input logic              clk,
  input logic              arm_n,
  input logic              key_in,
  input logic [CODE_W-1:0] code_in,
  input logic              open_n,
  input logic              alarm
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !arm_n |-> (open_n && !alarm));

  // R3
  open_with_key_chk: assert property (@(posedge clk) disable iff (!arm_n)
    !open_n |-> $past(key_in));

  // R3
  open_needs_match_chk: assert property (@(posedge clk) disable iff (!arm_n)
    $fell(open_n) |-> ($past(key_in) && $past(code_in) == LOCK_CODE));

  // R4
  close_on_withdraw_chk: assert property (@(posedge clk) disable iff (!arm_n)
    (!open_n && !key_in) |=> open_n);

  // R6
  alarm_from_miss_chk: assert property (@(posedge clk) disable iff (!arm_n)
    $rose(alarm) |-> ($past(key_in) && $past(code_in) != LOCK_CODE));

  // R7
  lockout_closed_chk: assert property (@(posedge clk) disable iff (!arm_n)
    alarm |-> open_n);

  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!arm_n)
    alarm |=> alarm);
endmodule

bind keycode_lock lock_chk #(.CODE_W(CODE_W), .LOCK_CODE(LOCK_CODE)) u_chk (
  .clk(clk), .arm_n(arm_n), .key_in(key_in), .code_in(code_in),
  .open_n(open_n), .alarm(alarm)
);

// File: tb/keycode_lock_test.sv
module keycode_lock_test;
  localparam logic [4:0] GOOD = 5'b01101;

  logic       clk = 1'b0;
  logic       arm_n;
  logic       key_in;
  logic [4:0] code_in;
  logic       open_n;
  logic       alarm;

  keycode_lock uut (
    .clk(clk), .arm_n(arm_n), .key_in(key_in), .code_in(code_in),
    .open_n(open_n), .alarm(alarm)
  );

  always #5 clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model
  int m_rel;
  bit m_keyq;
  int m_fails;
  int m_mode;  // 0 closed, 1 open, 2 locked out

  task automatic model_reset();
    m_rel = 0; m_keyq = 1'b1; m_fails = 0; m_mode = 0;
  endtask

  always @(posedge clk) begin
    if (m_rel == 2) begin
      case (m_mode)
        0: if (key_in && !m_keyq) begin
             if (code_in == GOOD) begin m_mode = 1; m_fails = 0; end
             else begin
               m_fails++;
               if (m_fails >= 3) m_mode = 2;
             end
           end
        1: if (!key_in) m_mode = 0;
        default: ;
      endcase
      m_keyq = key_in;
    end else begin
      m_keyq = 1'b1;
    end
    if (arm_n && m_rel < 2) m_rel++;
    #1;
    if (checking) begin
      vectors++;
      if (open_n !== (m_mode != 1) || alarm !== (m_mode == 2)) begin
        miscompares++;
        $display("FAIL %s open_n=%b alarm=%b expected open_n=%b alarm=%b",
                 cur_req, open_n, alarm, (m_mode != 1), (m_mode == 2));
      end
    end
  end

  task automatic cyc(input bit k, input logic [4:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      key_in  = k;
      code_in = c;
    end
  endtask

  task automatic rearm(input bit k, input logic [4:0] c);
    @(negedge clk);
    arm_n = 1'b0; key_in = k; code_in = c;
    model_reset();
    @(negedge clk);
    // R1: async clear seen between edges
    vectors++;
    if (open_n !== 1'b1 || alarm !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 open_n=%b alarm=%b expected open_n=1 alarm=0",
               open_n, alarm);
    end
    arm_n = 1'b1;
  endtask

  initial begin
    arm_n = 1'b1; key_in = 1'b0; code_in = 5'b0;
    #1 arm_n = 1'b0;
    model_reset();
    checking = 1'b1;
    cyc(1'b0, 5'b0, 3);
    arm_n = 1'b1;
    cyc(1'b0, 5'b0, 4);

    cur_req = "R3";                       // correct insertion opens
    cyc(1'b1, GOOD, 4);
    cur_req = "R4";                       // withdrawal closes
    cyc(1'b0, GOOD, 3);

    cur_req = "R5";                       // one miss, then success
    cyc(1'b1, 5'b01100, 2); cyc(1'b0, 5'b0, 2);
    cyc(1'b1, GOOD, 2);     cyc(1'b0, 5'b0, 2);

    cur_req = "R8";                       // 2 miss, success, 2 miss: no alarm
    cyc(1'b1, 5'b00000, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b11111, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, GOOD, 2);     cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b11101, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b00001, 1); cyc(1'b0, 5'b0, 2);

    cur_req = "R6";                       // third miss since success
    cyc(1'b1, 5'b10000, 1); cyc(1'b0, 5'b0, 3);

    cur_req = "R7";                       // lockout ignores the correct code
    cyc(1'b1, GOOD, 3); cyc(1'b0, GOOD, 2); cyc(1'b1, GOOD, 2);
    cyc(1'b0, 5'b0, 2);

    cur_req = "R1";
    rearm(1'b0, 5'b0);
    cyc(1'b0, 5'b0, 3);
    cyc(1'b1, GOOD, 2); cyc(1'b0, 5'b0, 2);

    cur_req = "R9";                       // code change under held key
    cyc(1'b1, 5'b00110, 2);
    cyc(1'b1, GOOD, 3);
    cyc(1'b0, GOOD, 2);

    cur_req = "R2";                       // key held across re-enable
    cyc(1'b1, GOOD, 1);
    rearm(1'b1, GOOD);
    cyc(1'b1, GOOD, 5);
    cyc(1'b0, GOOD, 1);
    cyc(1'b1, GOOD, 2);
    cyc(1'b0, GOOD, 2);

    cur_req = "R1";                       // early attempt during release
    rearm(1'b0, 5'b0);
    cyc(1'b1, 5'b00011, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b00011, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b00011, 1); cyc(1'b0, 5'b0, 1);
    cyc(1'b1, 5'b00011, 1); cyc(1'b0, 5'b0, 3);

    @(negedge clk);
    checking = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule